// File: doc/BRIEF.md
# UART Receive Idle Data-Ready Flag

This block sits beside a UART receiver and its receive FIFO. Bytes below the FIFO interrupt threshold would otherwise wait with nothing to report them. The block times the quiet line after each received frame. A bit-period tick from the baud generator advances an idle counter that restarts on every stop-bit-complete strobe. Once 16 bit periods pass with no new frame, and the FIFO holds some data but fewer bytes than the trigger count, a data-ready flag is raised. For an 8-data-bit, 1-stop-bit frame, 16 bit periods is roughly 1.6 frame times.

Software sees the flag and an interrupt-enable bit in a small two-bit register. It drains the FIFO and then clears the flag by writing 0. The clear takes effect only when the flag was read as 1 beforehand. The interrupt output is the flag gated by the enable bit. A standby input returns the block to its reset state.

Top module: `rx_idle_ready`

## Requirements
- R1: After reset, `reg_rdata` is 0 and `irq` is 0.
- R2: The idle counter restarts at 0 and arms on `stop_done`. It advances by one on each `bit_tick` while armed, while `fifo_count` is non-zero and while it is below 16. It saturates at 16. Once it reaches 16, the flag (`reg_rdata` bit 0) becomes 1 on the next clock edge, provided 0 < `fifo_count` < `trig_level`.
- R3: The flag never sets while `fifo_count` >= `trig_level`. If the window has expired and the counter is still armed, the flag sets one edge after the occupancy drops below the trigger level.
- R4: With `fifo_count` equal to 0, bit ticks are not counted and the flag never sets.
- R5: `start_det` clears the counter and disarms it, so no set happens until a later `stop_done` and 16 more counted ticks. `stop_done` takes priority over `start_det` in the same cycle.
- R6: Each stop strobe produces at most one set. After a set, the counter is disarmed.
- R7: A write with `reg_wdata[0]`=1 leaves the flag unchanged. Every write loads `reg_wdata[1]` into the interrupt-enable bit (`reg_rdata` bit 1).
- R8: A write with `reg_wdata[0]`=0 clears the flag only if a read was made in an earlier cycle while the flag was 1. A successful clear discards that record. If a set and a clear occur in the same cycle, the set wins.
- R9: While `standby` is 1, the flag, the enable bit, the counter and the read record are all forced to 0.
- R10: A frame that arrives after the flag has set leaves the flag at 1 and rearms the counter from its stop strobe.
- R11: `irq` equals flag AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Low-power standby; holds the block in its reset state |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| stop_done | input | 1 | Stop bit of a received frame completed |
| start_det | input | 1 | Start bit of a new frame detected |
| fifo_count | input | CNT_W | Bytes currently in the receive FIFO |
| trig_level | input | CNT_W | Programmed receive trigger count |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 flag, bit 1 interrupt enable |
| reg_rdata | output | 2 | Read data: bit 0 flag, bit 1 interrupt enable |
| irq | output | 1 | Receive data-ready interrupt |

## Verification
Several rules are checked by the assertions on every cycle. The counter never exceeds 16. The flag never rises unless the FIFO was non-empty and below the trigger level. A write of 1 or an unrecorded write of 0 cannot drop the flag. Standby always empties the register, and the interrupt never appears without the flag. Only the bench's scenarios can show the exact 16-tick timing, the restart on a start bit, the single set per stop strobe, and the flag holding across a later frame. Its reference model follows the full read-then-clear sequence.

// File: rtl/rx_idle_ready.sv
module rx_idle_ready #(
  parameter int FIFO_DEPTH = 16,
  parameter int IDLE_BITS  = 16,
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
  localparam int IDLE_W = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             bit_tick,
  input  logic             stop_done,
  input  logic             start_det,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] trig_level,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [1:0]       reg_wdata,
  output logic [1:0]       reg_rdata,
  output logic             irq
);

  localparam logic [IDLE_W-1:0] IDLE_LIMIT = IDLE_W'(IDLE_BITS);

  logic [IDLE_W-1:0] idle_cnt;
  logic armed, flag, ie, seen;

  wire fifo_has = |fifo_count;
  wire below    = fifo_count < trig_level;
  wire expired  = idle_cnt == IDLE_LIMIT;
  wire set_flag = armed && expired && fifo_has && below;
  wire clr_ok   = reg_wr && !reg_wdata[0] && seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (standby) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (stop_done) begin
      idle_cnt <= '0;
      armed    <= 1'b1;
    end else if (start_det) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (set_flag) begin
      armed    <= 1'b0;
    end else if (armed && bit_tick && fifo_has && !expired) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      seen <= 1'b0;
      ie   <= 1'b0;
    end else if (standby) begin
      flag <= 1'b0;
      seen <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (set_flag)    flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;
      if (clr_ok)              seen <= 1'b0;
      else if (reg_rd && flag) seen <= 1'b1;
      if (reg_wr) ie <= reg_wdata[1];
    end
  end

  assign reg_rdata = {ie, flag};
  assign irq       = flag & ie;

endmodule

module rx_idle_ready_chk #(
  parameter int CNT_W  = 5,
  parameter int IDLE_W = 5,
  parameter int IDLE_BITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic [CNT_W-1:0] fifo_count,
  input logic [CNT_W-1:0] trig_level,
  input logic             reg_wr,
  input logic [1:0]       reg_wdata,
  input logic [1:0]       reg_rdata,
  input logic             irq,
  input logic             seen,
  input logic [IDLE_W-1:0] idle_cnt
);

  assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_W'(IDLE_BITS));

  assert_rise_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> $past(fifo_count != '0 && fifo_count < trig_level));

  assert_write1_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[0] && reg_rdata[0] && !standby) |=> reg_rdata[0]);

  assert_unread_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[0] && !seen && reg_rdata[0] && !standby) |=> reg_rdata[0]);

  assert_standby_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (reg_rdata == 2'b00 && !irq));

  assert_irq_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_rdata[0]);

endmodule

bind rx_idle_ready rx_idle_ready_chk #(
  .CNT_W(CNT_W), .IDLE_W(IDLE_W), .IDLE_BITS(IDLE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby),
  .fifo_count(fifo_count), .trig_level(trig_level),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq),
  .seen(seen), .idle_cnt(idle_cnt)
);

// File: tb/tb_rx_idle_ready.sv
module tb_rx_idle_ready;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 0, bit_tick = 0, stop_done = 0, start_det = 0;
  logic [CW-1:0] fifo_count = '0, trig_level = 5'd8;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_wdata = '0;
  logic [1:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  int  m_cnt;
  bit  m_armed, m_flag, m_ie, m_seen;

  always #5 clk = ~clk;

  rx_idle_ready dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bit_tick(bit_tick),
    .stop_done(stop_done), .start_det(start_det), .fifo_count(fifo_count),
    .trig_level(trig_level), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic bit ref_set();
    return m_armed && m_cnt == 16 && fifo_count != 0 && fifo_count < trig_level;
  endfunction

  task automatic model_step();
    bit s, c;
    if (!rst_n || standby) begin
      m_cnt = 0; m_armed = 0; m_flag = 0; m_ie = 0; m_seen = 0;
      return;
    end
    s = ref_set();
    c = reg_wr && !reg_wdata[0] && m_seen;
    if (stop_done) begin m_cnt = 0; m_armed = 1; end
    else if (start_det) begin m_cnt = 0; m_armed = 0; end
    else if (s) m_armed = 0;
    else if (m_armed && bit_tick && fifo_count != 0 && m_cnt < 16) m_cnt++;
    if (reg_rd && m_flag && !c) m_seen = 1;
    if (c) m_seen = 0;
    if (s) m_flag = 1; else if (c) m_flag = 0;
    if (reg_wr) m_ie = reg_wdata[1];
  endtask

  task automatic check(input logic [1:0] exp_r, input logic exp_i);
    checks++;
    if (reg_rdata !== exp_r || irq !== exp_i) begin
      errors++;
      $display("FAIL %s: rdata=%b irq=%b expected rdata=%b irq=%b",
               cur_req, reg_rdata, irq, exp_r, exp_i);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({m_ie, m_flag}, m_flag & m_ie);
    bit_tick = 0; stop_done = 0; start_det = 0;
    reg_rd = 0; reg_wr = 0; standby = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cycle(); end
  endtask

  task automatic frame_end();
    stop_done = 1; cycle();
  endtask

  task automatic rd();
    reg_rd = 1; cycle();
  endtask

  task automatic wr(input logic [1:0] d);
    reg_wr = 1; reg_wdata = d; cycle();
  endtask

  task automatic expect_flag(input bit f);
    checks++;
    if (reg_rdata[0] !== f) begin
      errors++;
      $display("FAIL %s: flag=%b expected %b", cur_req, reg_rdata[0], f);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    model_step();
    repeat (3) @(negedge clk);
    check(2'b00, 1'b0);
    rst_n = 1;
    cycle();

    cur_req = "R2";
    fifo_count = 3; trig_level = 8;
    frame_end(); ticks(15); cycle(); expect_flag(0);
    ticks(1); expect_flag(0); cycle(); expect_flag(1);
    rd(); wr(2'b00); expect_flag(0);

    cur_req = "R6";
    ticks(40); expect_flag(0);

    cur_req = "R3";
    fifo_count = 8; frame_end(); ticks(20); expect_flag(0);
    fifo_count = 7; cycle(); expect_flag(1);
    rd(); wr(2'b00);

    cur_req = "R4";
    fifo_count = 0; frame_end(); ticks(50); expect_flag(0);
    fifo_count = 2; ticks(15); cycle(); expect_flag(0);
    ticks(1); cycle(); expect_flag(1);
    rd(); wr(2'b00);

    cur_req = "R5";
    frame_end(); ticks(10); start_det = 1; cycle(); ticks(30); expect_flag(0);
    stop_done = 1; start_det = 1; cycle(); ticks(16); cycle(); expect_flag(1);

    cur_req = "R10";
    frame_end(); cycle(); expect_flag(1);
    cur_req = "R7";
    wr(2'b01); expect_flag(1);
    wr(2'b11); expect_flag(1);
    cur_req = "R11";
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R11: irq=%b expected 1", irq); end
    cur_req = "R8";
    wr(2'b10); expect_flag(1);
    rd(); wr(2'b10); expect_flag(0);
    wr(2'b00); expect_flag(0);

    cur_req = "R10";
    ticks(16); cycle(); expect_flag(1);

    cur_req = "R9";
    standby = 1; cycle();
    checks++;
    if (reg_rdata !== 2'b00) begin errors++; $display("FAIL R9: rdata=%b expected 00", reg_rdata); end
    ticks(20); expect_flag(0);

    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      fifo_count = CW'($urandom_range(0, 16));
      trig_level = CW'($urandom_range(1, 16));
      bit_tick  = ($urandom_range(0, 99) < 60);
      stop_done = ($urandom_range(0, 99) < 2);
      start_det = ($urandom_range(0, 99) < 1);
      reg_rd    = ($urandom_range(0, 99) < 10);
      reg_wr    = ($urandom_range(0, 99) < 4);
      reg_wdata = 2'($urandom_range(0, 3));
      standby   = ($urandom_range(0, 999) < 3);
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd7));
endmodule